// File: doc/BRIEF.md
# Countdown Event Timer with Autoreload

This block is a 32-bit down-counting event timer behind a simple register port. Software stores a repeat interval and a starting count, then sets the enable bit in the control register. The count steps down on each prescaled tick. When it runs out, the timer raises a pending interrupt flag. In periodic mode it then reloads from the interval register. In one-shot mode it stops and clears its own enable bit.

Because the starting count and the interval are separate registers, the first timeout can differ from the repeat period. Tick pulses come from one of two source strobes that are generated outside the block: a fast oscillator strobe and an auxiliary strobe. The chosen strobe goes through a power-of-two divider selected by a 3-bit code. The interrupt line is the pending flag gated by an enable bit. Software clears the flag by writing a one to it.

Top module: `evt_timer_top`

## Requirements
- R1: After reset, all registers (control, interval, current count, interrupt enable, pending flag) read as zero and `irq` is low.
- R2: Register map, by byte address:
  - 0x00: interrupt enable, bit 0.
  - 0x04: pending flag, bit 0.
  - 0x10: control, with run enable in bit 0, periodic select in bit 1, source select in bit 2 and divider code in bits [6:4].
  - 0x14: interval.
  - 0x18: current count.
  Written fields read back, and unused bits read zero.
- R3: While enabled, the current count falls by one on each prescaled tick. A start count N≥1 expires on the Nth tick after enable, and a start count of 0 expires on the first tick.
- R4: A prescaled tick occurs once every 2^code pulses of the selected source, for codes 0 to 7. Source select 1 picks `osc_tick` and 0 picks `aux_tick`. The divider restarts from zero each time the run enable is set.
- R5: In periodic mode the count reloads from the interval register at expiry. The next expiry follows after interval ticks.
- R6: In one-shot mode, expiry clears the run enable bit and leaves the count at zero. No further expiry follows.
- R7: Clearing the run enable freezes the current count and keeps the other control fields unchanged.
- R8: The pending flag is set at expiry even when the interrupt enable is 0. `irq` is the pending flag ANDed with the interrupt enable.
- R9: Writing 1 to bit 0 of the pending register clears the flag. If an expiry lands in the same cycle, the flag stays set.
- R10: A write to the current-count register takes effect over a tick in the same cycle. It sets the count from which the next expiry is measured, so the first period may differ from the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| osc_tick | input | 1 | Oscillator source strobe, one pulse per source period |
| aux_tick | input | 1 | Auxiliary source strobe |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 32-bit count and a 3-bit divider code. Those values bring the full register map and all eight divider ratios within reach. The stimulus uses codes 0 to 4, which keeps every expiry within a few dozen cycles while still showing the count-per-tick spacing exactly. The oscillator strobe is held high, so expiry cycles can be predicted to the edge. The auxiliary strobe toggles every cycle, which tests source selection and checks that the periodic spacing is exact regardless of strobe phase.

// File: rtl/evt_timer_pkg.sv
// Package: shared register offsets and control field positions for the
// countdown event timer. Assumes byte addressing on an 8-bit address.
package evt_timer_pkg;
    localparam int OFS_IE   = 'h00;
    localparam int OFS_STA  = 'h04;
    localparam int OFS_CTRL = 'h10;
    localparam int OFS_IVAL = 'h14;
    localparam int OFS_CUR  = 'h18;

    localparam int BIT_EN       = 0;
    localparam int BIT_AUTO     = 1;
    localparam int BIT_SRC      = 2;
    localparam int CODE_LSB     = 4;
endpackage

// File: rtl/evt_timer_prescale.sv
// Module: picks one of two source strobes and divides it by 2**code.
// Assumes the strobes are single-cycle enables in the clk domain.
// The divide counter is held at zero while run is low, so each rising
// edge of run starts a fresh division.
module evt_timer_prescale #(
    parameter int PRE_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             src_sel,
    input  logic             osc_tick,
    input  logic             aux_tick,
    input  logic [PRE_W-1:0] code,
    output logic             tick
);
    localparam int DIV_W = (1 << PRE_W) - 1;

    logic [DIV_W-1:0] div_cnt;
    logic [DIV_W-1:0] div_lim;
    logic             src_pulse;

    // Select source and compute the terminal count for the current code.
    always_comb begin
        src_pulse = src_sel ? osc_tick : aux_tick;
        div_lim   = (DIV_W'(1) << code) - DIV_W'(1);
        tick      = run && src_pulse && (div_cnt == div_lim);
    end

    // Divide counter: cleared while stopped, wraps at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_cnt <= '0;
        end else if (src_pulse) begin
            div_cnt <= (div_cnt == div_lim) ? '0 : div_cnt + DIV_W'(1);
        end
    end

    AST_PRE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(run) && div_lim != '0) |-> !tick); // R4
endmodule

// File: rtl/evt_timer_count.sv
// Module: the down-counter with reload/stop on expiry.
// Assumes the tick input is already gated by the run enable.
// A software load of the count overrides a tick in the same cycle.
module evt_timer_count #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             periodic,
    input  logic             load_cur,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] interval,
    output logic [CNT_W-1:0] cur,
    output logic             expire
);
    logic last_step;

    // Expiry is the tick that takes the count from one (or zero) to done.
    always_comb begin
        last_step = (cur <= CNT_W'(1));
        expire    = tick && !load_cur && last_step;
    end

    // Count register: software load, reload, stop at zero, or decrement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
        end else if (load_cur) begin
            cur <= load_val;
        end else if (tick) begin
            if (last_step) begin
                cur <= periodic ? interval : '0;
            end else begin
                cur <= cur - CNT_W'(1);
            end
        end
    end

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load_cur && cur > CNT_W'(1)) |=> (cur == $past(cur) - CNT_W'(1))); // R3
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && periodic) |=> (cur == $past(interval))); // R5
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_cur) |=> $stable(cur)); // R7
    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        load_cur |=> (cur == $past(load_val))); // R10
endmodule

// File: rtl/evt_timer_top.sv
// Module: register file, interrupt logic and wiring for the countdown
// event timer. Assumes a single-cycle write strobe and a combinational
// read path; byte addresses are compared in full.
module evt_timer_top
    import evt_timer_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int PRE_W  = 3,
    parameter int ADDR_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        osc_tick,
    input  logic        aux_tick,
    input  logic        bus_we,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);
    logic             ie_q;
    logic             pend_q;
    logic             en_q;
    logic             auto_q;
    logic             src_q;
    logic [PRE_W-1:0] code_q;
    logic [CNT_W-1:0] ival_q;
    logic [CNT_W-1:0] cur;
    logic             tick;
    logic             expire;
    logic             wr_ie, wr_sta, wr_ctrl, wr_ival, wr_cur;

    // Address decode of write strobes.
    always_comb begin
        wr_ie   = bus_we && (bus_addr == ADDR_W'(OFS_IE));
        wr_sta  = bus_we && (bus_addr == ADDR_W'(OFS_STA));
        wr_ctrl = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
        wr_ival = bus_we && (bus_addr == ADDR_W'(OFS_IVAL));
        wr_cur  = bus_we && (bus_addr == ADDR_W'(OFS_CUR));
    end

    // Control register: software write, or self-clear of enable in one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= 1'b0;
            auto_q <= 1'b0;
            src_q  <= 1'b0;
            code_q <= '0;
        end else if (wr_ctrl) begin
            en_q   <= bus_wdata[BIT_EN];
            auto_q <= bus_wdata[BIT_AUTO];
            src_q  <= bus_wdata[BIT_SRC];
            code_q <= bus_wdata[CODE_LSB +: PRE_W];
        end else if (expire && !auto_q) begin
            en_q   <= 1'b0;
        end
    end

    // Interval and interrupt enable registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ival_q <= '0;
            ie_q   <= 1'b0;
        end else begin
            if (wr_ival) ival_q <= bus_wdata[CNT_W-1:0];
            if (wr_ie)   ie_q   <= bus_wdata[0];
        end
    end

    // Pending flag: write-one-to-clear, a coincident expiry wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else begin
            pend_q <= (pend_q && !(wr_sta && bus_wdata[0])) || expire;
        end
    end

    assign irq = pend_q && ie_q;

    // Read multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFS_IE):   bus_rdata[0] = ie_q;
            ADDR_W'(OFS_STA):  bus_rdata[0] = pend_q;
            ADDR_W'(OFS_CTRL): begin
                bus_rdata[BIT_EN]               = en_q;
                bus_rdata[BIT_AUTO]             = auto_q;
                bus_rdata[BIT_SRC]              = src_q;
                bus_rdata[CODE_LSB +: PRE_W]    = code_q;
            end
            ADDR_W'(OFS_IVAL): bus_rdata = 32'(ival_q);
            ADDR_W'(OFS_CUR):  bus_rdata = 32'(cur);
            default:           bus_rdata = '0;
        endcase
    end

    evt_timer_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (en_q),
        .src_sel  (src_q),
        .osc_tick (osc_tick),
        .aux_tick (aux_tick),
        .code     (code_q),
        .tick     (tick)
    );

    evt_timer_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .periodic (auto_q),
        .load_cur (wr_cur),
        .load_val (bus_wdata[CNT_W-1:0]),
        .interval (ival_q),
        .cur      (cur),
        .expire   (expire)
    );

    AST_ONESHOT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !auto_q && !wr_ctrl) |=> !en_q); // R6
    AST_PEND_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> pend_q); // R8
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sta && bus_wdata[0] && !expire) |=> !pend_q); // R9
    AST_STOP_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ctrl && !expire) |=> ($stable(code_q) && $stable(src_q) && $stable(auto_q))); // R7
endmodule

// File: tb/tb_evt_timer_top.sv
module tb_evt_timer_top;
    localparam int CLK_P = 10;
    localparam int A_IE = 'h00, A_STA = 'h04, A_CTRL = 'h10, A_IVAL = 'h14, A_CUR = 'h18;
    localparam int NV = 6;
    localparam int LIMIT = 80;
    // fields: start, interval, periodic, code, src, first expiry edge, spacing (-1 none)
    localparam int VEC [NV][7] = '{
        '{3, 5, 1, 0, 1,  3,  5},
        '{2, 4, 1, 2, 1,  8, 16},
        '{4, 9, 0, 1, 1,  8, -1},
        '{1, 2, 1, 4, 1, 16, 32},
        '{3, 2, 1, 1, 0, 12,  8},
        '{0, 3, 1, 0, 1,  1,  3}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b1;
    logic        aux_tick = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_chk = 0;
    int          n_err = 0;

    evt_timer_top dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .aux_tick(aux_tick),
        .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    initial forever begin
        @(negedge clk);
        aux_tick = ~aux_tick;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = 8'(a); bus_wdata = d;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = 8'(a);
        #1;
        d = bus_rdata;
    endtask

    // Counts edges after the last write; clears the flag one edge after each sighting.
    task automatic measure(output int t1, output int t2, output int irq_bad);
        t1 = -1; t2 = -1; irq_bad = 0;
        bus_addr = 8'(A_STA);
        for (int k = 1; k <= LIMIT; k++) begin
            @(posedge clk); #1;
            bus_we = 1'b0;
            bus_addr = 8'(A_STA);
            #1;
            if (bus_rdata[0]) begin
                if (irq) irq_bad = 1;
                if (t1 < 0) t1 = k;
                else if (t2 < 0) t2 = k;
                bus_we = 1'b1; bus_wdata = 32'h1;
            end
        end
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    initial begin
        #(CLK_P * 200000);
        n_err++; n_chk++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        logic [31:0] v, v2;
        int t1, t2, ib, d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset values
        rd(A_CTRL, v); chk(v == 0, "R1 ctrl", v, 0);
        rd(A_IVAL, v); chk(v == 0, "R1 interval", v, 0);
        rd(A_CUR, v);  chk(v == 0, "R1 count", v, 0);
        rd(A_IE, v);   chk(v == 0, "R1 ie", v, 0);
        rd(A_STA, v);  chk(v == 0, "R1 pending", v, 0);
        chk(irq == 0, "R1 irq", irq, 0);

        // R2: readback and unused bits
        wr(A_CTRL, 32'hFFFF_FF76); rd(A_CTRL, v); chk(v == 32'h76, "R2 ctrl", v, 32'h76);
        wr(A_IVAL, 32'hDEAD_BEEF); rd(A_IVAL, v); chk(v == 32'hDEAD_BEEF, "R2 interval", v, 32'hDEAD_BEEF);
        wr(A_IE, 32'hFFFF_FFFF);   rd(A_IE, v);   chk(v == 1, "R2 ie", v, 1);
        wr(A_IE, 32'h0);
        wr(A_CTRL, 32'h0);

        // R3 R4 R5 R6 R8 R10: vector table
        for (int i = 0; i < NV; i++) begin
            wr(A_CTRL, 32'h0);
            wr(A_STA, 32'h1);
            wr(A_IVAL, 32'(VEC[i][1]));
            wr(A_CUR, 32'(VEC[i][0]));
            wr(A_CTRL, 32'(1 | (VEC[i][2] << 1) | (VEC[i][4] << 2) | (VEC[i][3] << 4)));
            measure(t1, t2, ib);
            if (VEC[i][4] == 1)
                chk(t1 == VEC[i][5], "R3 R4 R10 first expiry edge", t1, VEC[i][5]);
            else
                chk(t1 == VEC[i][5] || t1 == VEC[i][5] - 1, "R4 aux source first expiry", t1, VEC[i][5]);
            if (VEC[i][6] < 0) begin
                chk(t2 == -1, "R6 no second expiry", t2, -1);
                rd(A_CTRL, v); chk(v[0] == 1'b0, "R6 enable cleared", v[0], 0);
                rd(A_CUR, v);  chk(v == 0, "R6 count at zero", v, 0);
            end else begin
                chk(t2 - t1 == VEC[i][6], "R5 reload spacing", t2 - t1, VEC[i][6]);
            end
            chk(ib == 0, "R8 irq masked while pending", ib, 0);
        end
        wr(A_CTRL, 32'h0);
        wr(A_STA, 32'h1);

        // R8: unmasked interrupt follows pending
        wr(A_IE, 32'h1);
        wr(A_CUR, 32'd2);
        wr(A_CTRL, 32'h05);
        repeat (2) @(posedge clk);
        #1;
        chk(irq == 1'b1, "R8 irq on expiry", irq, 1);
        wr(A_STA, 32'h1);
        chk(irq == 1'b0, "R8 irq after clear", irq, 0);
        wr(A_IE, 32'h0);

        // R7: stop freezes count, keeps other fields
        wr(A_IVAL, 32'd1000);
        wr(A_CUR, 32'd1000);
        wr(A_CTRL, 32'h37);
        repeat (20) @(posedge clk);
        wr(A_CTRL, 32'h36);
        rd(A_CUR, v);
        chk(v < 1000 && v > 0, "R3 count decreased", v, 999);
        repeat (30) @(posedge clk);
        #1;
        rd(A_CUR, v2); chk(v2 == v, "R7 count frozen", v2, v);
        rd(A_CTRL, v); chk(v == 32'h36, "R7 fields kept", v, 32'h36);
        rd(A_STA, v);  chk(v == 0, "R7 no expiry while stopped", v, 0);

        // R9: clear coinciding with expiry
        wr(A_CTRL, 32'h0);
        wr(A_IVAL, 32'd3);
        wr(A_CUR, 32'd3);
        wr(A_CTRL, 32'h07);
        bus_addr = 8'(A_STA);
        for (int k = 1; k <= 5; k++) begin
            @(posedge clk); #1;
        end
        bus_we = 1'b1; bus_wdata = 32'h1;
        @(posedge clk); #1;
        bus_we = 1'b0; #1;
        chk(bus_rdata[0] == 1'b1, "R9 expiry beats clear", bus_rdata[0], 1);
        bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0; #1;
        chk(bus_rdata[0] == 1'b0, "R9 clear", bus_rdata[0], 0);
        wr(A_CTRL, 32'h0);

        d = 0;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk + d);
        $finish;
    end
endmodule